// File: doc/BRIEF.md
# Extended-Precision Multiply Accumulator

This block is a 32-bit multiply/accumulate unit. It holds a 64-bit accumulator made of a high word and a low word. An 8-bit extension word sits above the accumulator. Its job is to count the carries that leave the top of the 64-bit sum, so a long run of unsigned multiply-adds keeps its full precision. A signed multiply overwrites the accumulator and empties the extension word.

Two word-wise transfers move data across the three-level chain formed by the extension, high and low words:

- The drain operation hands the low word out on the result port. It then shifts every level down by one.
- The fill operation shifts every level up by one and places an operand word at the bottom.

Together these let software read out, or reload, a value wider than 64 bits one word at a time.

Each operation is presented for one cycle with a valid strobe, an opcode and two operands. The state changes on that clock edge. The drain result is available combinationally in the same cycle.

Top module: `widemac_unit`

## Requirements
- R1: A synchronous active-high reset clears the high word, the low word and the extension word to zero.
- R2: The opcode is 3 bits wide: 0 is idle, 1 is signed multiply, 2 is unsigned multiply-add, 3 is drain and 4 is fill. Codes 5, 6 and 7 leave all state unchanged.
- R3: Signed multiply writes the 64-bit two's-complement product of the operands to high:low and forces the extension word to zero.
- R4: Unsigned multiply-add adds the 64-bit unsigned product of the operands to high:low, modulo 2^64. The upper half of the sum goes to high and the lower half goes to low.
- R5: When the multiply-add sum wraps past 2^64, the extension word is incremented by one, modulo 256. Otherwise the extension word keeps its value.
- R6: While valid is high and the opcode is drain, the result port shows the low word held before the edge. In every other cycle the result port is zero.
- R7: Drain loads low with the old high word and loads high with the old extension word, zero-extended. It then clears the extension word.
- R8: Fill loads the extension word with bits 7:0 of the old high word, loads high with the old low word, and loads low with operand a.
- R9: When valid is low, no state changes, whatever the opcode and operands are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Qualifies the operation for this cycle |
| op_i | input | 3 | Operation code (see R2) |
| a_i | input | 32 | First operand; also the word loaded by fill |
| b_i | input | 32 | Second operand |
| result_o | output | 32 | Drain result (the pre-update low word) |
| hi_o | output | 32 | Current high accumulator word |
| lo_o | output | 32 | Current low accumulator word |
| ext_o | output | 8 | Current carry extension word |

## Verification
Two pairs of functions land in the same cycle here.

The first pair is the drain read and the chain shift. The result port must show the old low word while the registers take their shifted values on that same edge. The bench samples the result before the edge and the shifted state after it.

The second pair is a multiply-add carry and the extension word wrapping. The bench uses fills to load an extension of 255 above an all-ones accumulator. It then issues a multiply-add of 1×1 and expects a zero accumulator and a zero extension in a single step.

Random mixes of all eight opcodes, with valid toggling, are compared against a reference model in the bench after every edge.

// File: rtl/widemac_pkg.sv
package widemac_pkg;

    localparam int WORD_W = 32;
    localparam int EXT_W  = 8;
    localparam int OP_W   = 3;

    typedef enum logic [OP_W-1:0] {
        OP_IDLE  = 3'd0,
        OP_SMUL  = 3'd1,
        OP_UMADD = 3'd2,
        OP_DRAIN = 3'd3,
        OP_FILL  = 3'd4
    } mac_op_e;

    typedef struct packed {
        logic load_prod;   // overwrite accumulator with product
        logic accumulate;  // add product into accumulator
        logic drain;       // shift chain down, emit low word
        logic fill;        // shift chain up, insert operand
        logic signed_mul;  // multiplier treats operands as signed
    } mac_ctrl_t;

    function automatic mac_ctrl_t decode_op(input logic valid, input logic [OP_W-1:0] op);
        mac_ctrl_t c;
        c = '0;
        if (valid) begin
            case (op)
                OP_SMUL: begin
                    c.load_prod  = 1'b1;
                    c.signed_mul = 1'b1;
                end
                OP_UMADD: c.accumulate = 1'b1;
                OP_DRAIN: c.drain      = 1'b1;
                OP_FILL:  c.fill       = 1'b1;
                default:  c = '0;
            endcase
        end
        return c;
    endfunction

    function automatic logic [2*WORD_W-1:0] widen(input logic [WORD_W-1:0] v, input logic sgn);
        return sgn ? {{WORD_W{v[WORD_W-1]}}, v} : {{WORD_W{1'b0}}, v};
    endfunction

endpackage

// File: rtl/widemac_decode.sv
module widemac_decode
    import widemac_pkg::*;
#(
    parameter int OPW = OP_W
) (
    input  logic           valid_i,
    input  logic [OPW-1:0] op_i,
    output mac_ctrl_t      ctrl_o
);
    always_comb begin
        ctrl_o = decode_op(valid_i, op_i);
    end
endmodule

// File: rtl/widemac_mul.sv
module widemac_mul
    import widemac_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    input  logic           sgn_i,
    output logic [2*W-1:0] prod_o
);
    localparam int PW = 2 * W;

    logic [PW-1:0] ax;
    logic [PW-1:0] bx;

    always_comb begin
        ax = sgn_i ? {{W{a_i[W-1]}}, a_i} : {{W{1'b0}}, a_i};
        bx = sgn_i ? {{W{b_i[W-1]}}, b_i} : {{W{1'b0}}, b_i};
        prod_o = ax * bx;
    end
endmodule

// File: rtl/widemac_adder.sv
module widemac_adder #(
    parameter int W = 32
) (
    input  logic [2*W-1:0] acc_i,
    input  logic [2*W-1:0] prod_i,
    output logic [2*W-1:0] sum_o,
    output logic           carry_o
);
    localparam int PW = 2 * W;

    logic [PW:0] full;

    always_comb begin
        full    = {1'b0, acc_i} + {1'b0, prod_i};
        sum_o   = full[PW-1:0];
        carry_o = full[PW];
    end
endmodule

// File: rtl/widemac_regs.sv
module widemac_regs #(
    parameter int W = 32,
    parameter int X = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load_prod_i,
    input  logic           accumulate_i,
    input  logic           drain_i,
    input  logic           fill_i,
    input  logic [W-1:0]   fill_word_i,
    input  logic [2*W-1:0] prod_i,
    input  logic [2*W-1:0] sum_i,
    input  logic           carry_i,
    output logic [W-1:0]   hi_o,
    output logic [W-1:0]   lo_o,
    output logic [X-1:0]   ext_o
);
    localparam int PAD = W - X;

    logic [W-1:0] hi_q, lo_q, hi_d, lo_d;
    logic [X-1:0] ext_q, ext_d;

    always_comb begin
        hi_d  = hi_q;
        lo_d  = lo_q;
        ext_d = ext_q;
        if (load_prod_i) begin
            {hi_d, lo_d} = prod_i;
            ext_d        = '0;
        end else if (accumulate_i) begin
            {hi_d, lo_d} = sum_i;
            ext_d        = ext_q + {{(X-1){1'b0}}, carry_i};
        end else if (drain_i) begin
            lo_d  = hi_q;
            hi_d  = {{PAD{1'b0}}, ext_q};
            ext_d = '0;
        end else if (fill_i) begin
            ext_d = hi_q[X-1:0];
            hi_d  = lo_q;
            lo_d  = fill_word_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q  <= '0;
            lo_q  <= '0;
            ext_q <= '0;
        end else begin
            hi_q  <= hi_d;
            lo_q  <= lo_d;
            ext_q <= ext_d;
        end
    end

    assign hi_o  = hi_q;
    assign lo_o  = lo_q;
    assign ext_o = ext_q;
endmodule

// File: rtl/widemac_unit.sv
module widemac_unit
    import widemac_pkg::*;
#(
    parameter int W   = WORD_W,
    parameter int X   = EXT_W,
    parameter int OPW = OP_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           valid_i,
    input  logic [OPW-1:0] op_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    output logic [W-1:0]   result_o,
    output logic [W-1:0]   hi_o,
    output logic [W-1:0]   lo_o,
    output logic [X-1:0]   ext_o
);
    localparam int PW = 2 * W;

    mac_ctrl_t     ctrl;
    logic [PW-1:0] prod;
    logic [PW-1:0] sum;
    logic          carry;
    logic [W-1:0]  hi_w, lo_w;
    logic [X-1:0]  ext_w;

    widemac_decode #(.OPW(OPW)) u_dec (
        .valid_i (valid_i),
        .op_i    (op_i),
        .ctrl_o  (ctrl)
    );

    widemac_mul #(.W(W)) u_mul (
        .a_i    (a_i),
        .b_i    (b_i),
        .sgn_i  (ctrl.signed_mul),
        .prod_o (prod)
    );

    widemac_adder #(.W(W)) u_add (
        .acc_i   ({hi_w, lo_w}),
        .prod_i  (prod),
        .sum_o   (sum),
        .carry_o (carry)
    );

    widemac_regs #(.W(W), .X(X)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .load_prod_i  (ctrl.load_prod),
        .accumulate_i (ctrl.accumulate),
        .drain_i      (ctrl.drain),
        .fill_i       (ctrl.fill),
        .fill_word_i  (a_i),
        .prod_i       (prod),
        .sum_i        (sum),
        .carry_i      (carry),
        .hi_o         (hi_w),
        .lo_o         (lo_w),
        .ext_o        (ext_w)
    );

    assign result_o = ctrl.drain ? lo_w : '0;
    assign hi_o     = hi_w;
    assign lo_o     = lo_w;
    assign ext_o    = ext_w;
endmodule

// File: rtl/widemac_checker.sv
module widemac_checker #(
    parameter int W   = 32,
    parameter int X   = 8,
    parameter int OPW = 3
) (
    input logic           clk,
    input logic           rst,
    input logic           valid_i,
    input logic [OPW-1:0] op_i,
    input logic [W-1:0]   a_i,
    input logic [W-1:0]   result_o,
    input logic [W-1:0]   hi_o,
    input logic [W-1:0]   lo_o,
    input logic [X-1:0]   ext_o
);
    logic past_ok;
    always_ff @(posedge clk) past_ok <= !rst;

    a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (hi_o == '0 && lo_o == '0 && ext_o == '0));

    a_r9_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(valid_i)) |-> ($stable(hi_o) && $stable(lo_o) && $stable(ext_o)));

    a_r2_unused_codes_hold: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(valid_i) && $past(op_i) > 3'd4)
            |-> ($stable(hi_o) && $stable(lo_o) && $stable(ext_o)));

    a_r3_smul_clears_ext: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(valid_i) && $past(op_i) == 3'd1) |-> ext_o == '0);

    a_r5_ext_step: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(valid_i) && $past(op_i) == 3'd2)
            |-> (ext_o == $past(ext_o) || ext_o == $past(ext_o) + 1'b1));

    a_r6_drain_result: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == 3'd3) |-> result_o == lo_o);

    a_r6_quiet_result: assert property (@(posedge clk) disable iff (rst)
        !(valid_i && op_i == 3'd3) |-> result_o == '0);

    a_r7_drain_shift: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(valid_i) && $past(op_i) == 3'd3)
            |-> (lo_o == $past(hi_o) && hi_o == {{(W-X){1'b0}}, $past(ext_o)} && ext_o == '0));

    a_r8_fill_shift: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(valid_i) && $past(op_i) == 3'd4)
            |-> (ext_o == $past(hi_o[X-1:0]) && hi_o == $past(lo_o) && lo_o == $past(a_i)));
endmodule

bind widemac_unit widemac_checker #(.W(W), .X(X), .OPW(OPW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .valid_i  (valid_i),
    .op_i     (op_i),
    .a_i      (a_i),
    .result_o (result_o),
    .hi_o     (hi_o),
    .lo_o     (lo_o),
    .ext_o    (ext_o)
);

// File: tb/sim_widemac_unit.sv
module sim_widemac_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_i = 1'b0;
    logic [2:0]  op_i = 3'd0;
    logic [31:0] a_i = '0, b_i = '0;
    logic [31:0] result_o, hi_o, lo_o;
    logic [7:0]  ext_o;

    logic [31:0] m_hi = '0, m_lo = '0;
    logic [7:0]  m_ext = '0;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    widemac_unit u0 (
        .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i),
        .a_i(a_i), .b_i(b_i), .result_o(result_o),
        .hi_o(hi_o), .lo_o(lo_o), .ext_o(ext_o)
    );

    function automatic logic [63:0] sprod(input logic [31:0] a, input logic [31:0] b);
        logic signed [63:0] p;
        p = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
        return p;
    endfunction

    function automatic logic [64:0] umadd(input logic [63:0] acc, input logic [31:0] a, input logic [31:0] b);
        logic [63:0] p;
        p = {32'd0, a} * {32'd0, b};
        return {1'b0, acc} + {1'b0, p};
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_state(input string tag);
        check({tag, " hi"},  {32'd0, hi_o},  {32'd0, m_hi});
        check({tag, " lo"},  {32'd0, lo_o},  {32'd0, m_lo});
        check({tag, " ext"}, {56'd0, ext_o}, {56'd0, m_ext});
    endtask

    // Called at a falling edge; leaves at the next falling edge.
    task automatic step(input logic v, input logic [2:0] op, input logic [31:0] a,
                        input logic [31:0] b, input string tag);
        logic [64:0] s;
        valid_i = v; op_i = op; a_i = a; b_i = b;
        #1;
        // R6: drain output is combinational from the pre-edge low word
        check("R6 result", {32'd0, result_o}, {32'd0, (v && op == 3'd3) ? m_lo : 32'd0});
        @(posedge clk);
        if (v) begin
            case (op)
                3'd1: begin {m_hi, m_lo} = sprod(a, b); m_ext = 8'd0; end
                3'd2: begin
                    s = umadd({m_hi, m_lo}, a, b);
                    {m_hi, m_lo} = s[63:0];
                    m_ext = m_ext + {7'd0, s[64]};
                end
                3'd3: begin m_lo = m_hi; m_hi = {24'd0, m_ext}; m_ext = 8'd0; end
                3'd4: begin m_ext = m_hi[7:0]; m_hi = m_lo; m_lo = a; end
                default: ;
            endcase
        end
        @(negedge clk);
        check_state(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_state("R1 reset");

        // R3 signed multiply, negative times positive
        step(1, 3'd1, 32'hFFFF_FFFD, 32'd7, "R3 smul neg");
        step(1, 3'd1, 32'h8000_0000, 32'h8000_0000, "R3 smul min");
        // R4 accumulate without carry
        step(1, 3'd2, 32'd3, 32'd5, "R4 umadd");
        step(1, 3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4 umadd big");
        // Build ext=FF above all-ones accumulator via fills (R8)
        step(1, 3'd4, 32'h0000_00FF, 32'd0, "R8 fill1");
        step(1, 3'd4, 32'hFFFF_FFFF, 32'd0, "R8 fill2");
        step(1, 3'd4, 32'hFFFF_FFFF, 32'd0, "R8 fill3");
        check("R8 ext loaded", {56'd0, ext_o}, 64'hFF);
        // R5 carry with wrap of the extension word
        step(1, 3'd2, 32'd1, 32'd1, "R5 carry wrap");
        check("R5 ext wrapped", {56'd0, ext_o}, 64'd0);
        check("R5 acc wrapped", {hi_o, lo_o}, 64'd0);
        // R5 single carry
        step(1, 3'd4, 32'hFFFF_FFFF, 32'd0, "R8 fill4");
        step(1, 3'd4, 32'hFFFF_FFFF, 32'd0, "R8 fill5");
        step(1, 3'd2, 32'd2, 32'd1, "R5 carry inc");
        check("R5 ext one", {56'd0, ext_o}, 64'd1);
        // R7 drain sequence
        step(1, 3'd3, 32'd0, 32'd0, "R7 drain1");
        step(1, 3'd3, 32'd0, 32'd0, "R7 drain2");
        step(1, 3'd3, 32'd0, 32'd0, "R7 drain3");
        // R2 unused codes and R9 valid low
        step(1, 3'd4, 32'h1234_5678, 32'd0, "R8 fill6");
        step(1, 3'd5, 32'hDEAD_BEEF, 32'd9, "R2 code5");
        step(1, 3'd6, 32'hDEAD_BEEF, 32'd9, "R2 code6");
        step(1, 3'd7, 32'hDEAD_BEEF, 32'd9, "R2 code7");
        step(0, 3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R9 invalid umadd");
        step(0, 3'd3, 32'd0, 32'd0, "R9 invalid drain");

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [31:0] ra, rb;
            ra = $urandom();
            rb = $urandom();
            if (i % 5 == 0) begin ra = 32'hFFFF_FFFF; end
            step(($urandom() % 8) != 0, 3'($urandom() % 8), ra, rb, "R4 random");
        end

        // R1 reset in mid-run
        rst = 1'b1; valid_i = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        m_hi = '0; m_lo = '0; m_ext = '0;
        check_state("R1 mid reset");

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule